// File: doc/BRIEF.md
# Differential Bitstream Decimator with Saturating Output

This block turns the outputs of two 1-bit delta-sigma modulators, one digitizing each side of a differential input, into a single 16-bit offset-binary conversion word. Each conversion is one pass of a single-stage accumulate-and-dump (sinc1) filter whose length of N = 2^LOG2_LEN modulator clocks places the first notch at the output rate. Both bitstreams are counted over the same window. The block takes the difference of the two counts and scales it to 16 bits. It then adds mid-scale, subtracts a signed offset correction word and saturates at the code rails.

A conversion starts on a one-cycle start pulse. The block delivers exactly one result per started conversion, with a one-cycle done pulse. There are no pipeline stages and no settling results to discard, so a system that switches the modulator inputs between conversions gets a valid word every time. The calibration logic elsewhere in the chip supplies a fresh offset word for every conversion. The result holds until the next conversion completes.

Top module: `diff_sinc1_decimator`

## Requirements
- R1: After a synchronous active-low reset, `result` is 32768 and `done` is 0.
- R2: A `start` pulse sampled while idle begins a conversion. `bit_p` and `bit_n` are counted on the N rising edges that follow the start edge. `done` is 1 only in the cycle after edge N+1 counted from the start edge.
- R3: Each accepted start yields exactly one `done` pulse. A `start` that arrives while a conversion is in progress, or in the cycle its result is formed, is ignored.
- R4: With P ones counted on `bit_p`, Q ones counted on `bit_n` and offset word F, the result is 32768 + (P - Q) * 2^(15 - LOG2_LEN) - F, as an unsigned 16-bit value before clamping.
- R5: Any value from R4 above 65535 gives 65535. Full positive scale (P - Q = N with F = 0) therefore gives 65535.
- R6: Any value from R4 below 0 gives 0. Full negative scale (P - Q = -N with F = 0) therefore gives 0.
- R7: With F = 0, bit 15 of the result is 1 exactly when P >= Q.
- R8: `offset_corr` is a two's-complement word in output LSBs. It is sampled on the edge that forms each result, so a different word can apply to every conversion.
- R9: `result` changes only on the edge that raises `done`, and otherwise holds its value whatever the bitstreams do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock; all logic runs on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin a conversion |
| bit_p | input | 1 | Bitstream from the positive-side modulator |
| bit_n | input | 1 | Bitstream from the negative-side modulator |
| offset_corr | input | OFS_W | Signed offset correction in output LSBs |
| result | output | 16 | Offset-binary conversion word |
| done | output | 1 | One-cycle pulse marking a new result |

## Verification
The bench builds the block with LOG2_LEN = 4. Each conversion is then 16 samples, and one count of difference is worth 2048 output codes. At that length, both rails, the mid-scale sign boundary and offset words that push a result over or under a rail can be reached with short, hand-chosen per-sample bit masks. The bench uses the default OFS_W = 16, so the full signed offset range is available. Because the window is short, the bench can also place a second start pulse at a chosen sample inside a conversion and count the `done` pulses exactly.

// File: rtl/ds_decim_pkg.sv
// Shared constants and types for the differential bitstream decimator.
// Assumes a 16-bit offset-binary output code.
package ds_decim_pkg;
    localparam int CODE_W = 16;
    typedef logic [CODE_W-1:0] code_t;
    localparam code_t CODE_MID = code_t'(1 << (CODE_W - 1));
    localparam code_t CODE_MAX = '1;
endpackage

// File: rtl/conv_sequencer.sv
// Conversion sequencer: accepts a start pulse when idle, opens a sampling
// window of exactly 2**LOG2_LEN cycles, then raises a one-cycle finish flag.
// Assumes start is synchronous to clk.
module conv_sequencer #(
    parameter int LOG2_LEN = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic clear,
    output logic sample_en,
    output logic finish
);
    logic                busy;
    logic [LOG2_LEN-1:0] idx;

    // Accept a start only when neither sampling nor forming a result.
    assign clear     = start && !busy && !finish;
    assign sample_en = busy;

    // Advance the sample index and close the window on its last sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            idx    <= '0;
            finish <= 1'b0;
        end else begin
            finish <= 1'b0;
            if (clear) begin
                busy <= 1'b1;
                idx  <= '0;
            end else if (busy) begin
                idx <= idx + 1'b1;
                if (&idx) begin
                    busy   <= 1'b0;
                    finish <= 1'b1;
                end
            end
        end
    end

    // R3
    busy_finish_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && finish));

    // R2
    finish_follows_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        finish |-> $past(busy));
endmodule

// File: rtl/bit_tally.sv
// Ones counter for one modulator bitstream over a sampling window.
// Assumes clear and enable never coincide; the count never exceeds 2**LOG2_LEN.
module bit_tally #(
    parameter int LOG2_LEN = 10,
    localparam int CW = LOG2_LEN + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          enable,
    input  logic          bit_in,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] FULL = CW'(1) << LOG2_LEN;

    // Dump on clear, otherwise add each sampled one inside the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (enable && bit_in) begin
            count <= count + 1'b1;
        end
    end

    // R4
    tally_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL);
endmodule

// File: rtl/code_former.sv
// Forms the output word: difference of two tallies, scaled by a left shift
// to 16 bits, plus mid-scale, minus the offset word, clamped at the rails.
// Assumes 1 <= LOG2_LEN <= 15 and OFS_W <= 16.
module code_former
    import ds_decim_pkg::*;
#(
    parameter int LOG2_LEN = 10,
    parameter int OFS_W    = 16,
    localparam int CW = LOG2_LEN + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             finish,
    input  logic [CW-1:0]    cnt_p,
    input  logic [CW-1:0]    cnt_n,
    input  logic [OFS_W-1:0] offset_corr,
    output code_t            result,
    output logic             done
);
    localparam int DW = CW + 1;
    localparam int WW = CODE_W + 4;
    localparam int SH = CODE_W - 1 - LOG2_LEN;
    localparam logic signed [WW-1:0] MID_W = WW'(CODE_MID);
    localparam logic signed [WW-1:0] MAX_W = WW'(CODE_MAX);

    logic signed [DW-1:0] diff;
    logic signed [WW-1:0] diff_w, ofs_w, shifted, total;
    code_t                clamped;

    // Signed count difference, widened, scaled, centred and offset.
    always_comb begin
        diff    = $signed({1'b0, cnt_p}) - $signed({1'b0, cnt_n});
        diff_w  = {{(WW-DW){diff[DW-1]}}, diff};
        ofs_w   = {{(WW-OFS_W){offset_corr[OFS_W-1]}}, offset_corr};
        shifted = diff_w <<< SH;
        total   = shifted + MID_W - ofs_w;
    end

    // Saturate the centred value into the unsigned code range.
    always_comb begin
        if (total < 0)
            clamped = '0;
        else if (total > MAX_W)
            clamped = CODE_MAX;
        else
            clamped = total[CODE_W-1:0];
    end

    // Capture the word and pulse done on the finish flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= CODE_MID;
            done   <= 1'b0;
        end else begin
            done <= finish;
            if (finish)
                result <= clamped;
        end
    end

    // R3
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));

    // R7
    sign_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (offset_corr == '0) && (cnt_p >= cnt_n)) |-> result[CODE_W-1]);
endmodule

// File: rtl/diff_sinc1_decimator.sv
// Top of the differential sinc1 decimator: one sequencer, one tally per
// modulator bitstream, and the output former. Window length 2**LOG2_LEN
// sets the first filter notch at the conversion rate.
// Assumes 1 <= LOG2_LEN <= 15 and 1 <= OFS_W <= 16.
module diff_sinc1_decimator
    import ds_decim_pkg::*;
#(
    parameter int LOG2_LEN = 10,
    parameter int OFS_W    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             bit_p,
    input  logic             bit_n,
    input  logic [OFS_W-1:0] offset_corr,
    output logic [15:0]      result,
    output logic             done
);
    localparam int CW = LOG2_LEN + 1;

    logic          clear, sample_en, finish;
    logic [1:0]    streams;
    logic [CW-1:0] tally [2];

    assign streams = {bit_n, bit_p};

    conv_sequencer #(.LOG2_LEN(LOG2_LEN)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .clear    (clear),
        .sample_en(sample_en),
        .finish   (finish)
    );

    for (genvar s = 0; s < 2; s++) begin : g_side
        bit_tally #(.LOG2_LEN(LOG2_LEN)) u_tally (
            .clk   (clk),
            .rst_n (rst_n),
            .clear (clear),
            .enable(sample_en),
            .bit_in(streams[s]),
            .count (tally[s])
        );
    end

    code_former #(.LOG2_LEN(LOG2_LEN), .OFS_W(OFS_W)) u_form (
        .clk        (clk),
        .rst_n      (rst_n),
        .finish     (finish),
        .cnt_p      (tally[0]),
        .cnt_n      (tally[1]),
        .offset_corr(offset_corr),
        .result     (result),
        .done       (done)
    );

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!done && result == CODE_MID));
endmodule

// File: tb/diff_sinc1_decimator_tb.sv
module diff_sinc1_decimator_tb;
    localparam int L = 4;
    localparam int N = 1 << L;
    localparam int STEP = 1 << (15 - L);

    logic        clk = 0, rst_n = 0, start = 0, bit_p = 0, bit_n = 0;
    logic [15:0] offset_corr = 0;
    logic [15:0] result;
    logic        done;
    int n_chk = 0, n_bad = 0;
    bit  finished = 0;

    always #4 clk = ~clk;

    diff_sinc1_decimator #(.LOG2_LEN(L), .OFS_W(16)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .bit_p(bit_p), .bit_n(bit_n),
        .offset_corr(offset_corr), .result(result), .done(done));

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int model(logic [N-1:0] pm, logic [N-1:0] nm, int off);
        int v = 32768 + ($countones(pm) - $countones(nm)) * STEP - off;
        if (v < 0) v = 0;
        if (v > 65535) v = 65535;
        return v;
    endfunction

    // Runs one conversion; extra_start_at >= 0 pulses start at that sample.
    task automatic convert(string req, logic [N-1:0] pm, logic [N-1:0] nm,
                           int off, int extra_start_at);
        int exp = model(pm, nm, off);
        offset_corr = 16'(off);
        start = 1;
        @(negedge clk);
        start = 0;
        for (int i = 0; i < N; i++) begin
            bit_p = pm[i];
            bit_n = nm[i];
            start = (i == extra_start_at);
            @(negedge clk);
        end
        start = 0;
        check({req, " R2 done early"}, done, 0);
        @(negedge clk);
        check({req, " R2 done"}, done, 1);
        check(req, result, exp);
        @(negedge clk);
        check({req, " R3 single done"}, done, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 done", done, 0);
        check("R1 result", result, 32768);
    endtask

    task automatic t_rails();
        convert("R5 full positive", '1, '0, 0, -1);
        convert("R5 over after offset", 16'h7FFF, '0, -2048, -1);
        convert("R6 full negative", '0, '1, 0, -1);
        convert("R6 under after offset", '0, '1, 5, -1);
        convert("R6 negative offset lifts rail", '0, '1, -5, -1);
    endtask

    task automatic t_patterns();
        convert("R4 equal streams", '1, '1, 0, -1);
        check("R7 sign at equality", result[15], 1);
        convert("R4 minus one count", 16'h00F0, 16'h01F0, 0, -1);
        check("R7 sign below", result[15], 0);
        convert("R4 mixed pattern", 16'hA5C3, 16'h1248, 0, -1);
        convert("R4 alternating", 16'h5555, 16'hAAAA, 0, -1);
    endtask

    task automatic t_offset();
        convert("R8 positive offset", 16'h0F0F, 16'h0F0F, 100, -1);
        convert("R8 negative offset", 16'h0F0F, 16'h0F0F, -300, -1);
        convert("R8 offset on diff", 16'h00FF, 16'h000F, 1234, -1);
    endtask

    task automatic t_ignored_start();
        int pulses = 0;
        convert("R3 start mid conversion", 16'h3333, 16'h0101, 0, 5);
        for (int c = 0; c < 3 * N; c++) begin
            @(negedge clk);
            pulses += done;
        end
        check("R3 no extra conversion", pulses, 0);
    endtask

    task automatic t_hold();
        logic [15:0] held;
        convert("R9 prime", 16'hFFFF, 16'h0003, 0, -1);
        held = result;
        for (int c = 0; c < 40; c++) begin
            bit_p = c[0];
            bit_n = c[1];
            offset_corr = 16'(c * 77);
            @(negedge clk);
        end
        check("R9 held result", result, held);
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_rails();
        t_patterns();
        t_offset();
        t_ignored_start();
        t_hold();
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule